// File: doc/BRIEF.md
# Timer Event Status Register with Read-Then-Clear Flags

This block keeps the sticky event flags for one timer channel and presents them as a 16-bit status word on a simple register bus. Eight flags share the low byte: three interval-interrupt flags, one counter-overflow flag and four input-capture flags. The timer logic raises each flag with a one-cycle event pulse. The flag then stays set until software clears it.

A clear works in two steps. Software first reads the register while the flag is 1, which arms that bit. It then writes 0 to the same bit. A 0 write to a bit that has not been armed does nothing, and a 1 write never does anything. This protects against clearing an event that software has never seen. The upper byte reads as zero and ignores writes.

A combined interrupt request is the OR of all flags, each gated by its own enable bit from an input mask. The read and write strobes arrive already decoded for this register's address.

Top module: `tsr_status_reg`

## Requirements
- R1: After reset all flags and all armed states are 0, `rd_data` is 0 and `irq` is 0.
- R2: `rd_data[7:0]` shows the flags combinationally, from bit 7 down to bit 0: interval 2B, interval 2A, interval 1, overflow, capture D, capture C, capture B, capture A. `evt[i]` drives the flag at bit i.
- R3: An `evt[i]` pulse makes flag i read 1 after the next clock edge, and the flag stays 1 without a qualifying clear.
- R4: Writing 1 to a flag bit never changes that flag.
- R5: Writing 0 to a flag bit that was not read as 1 since the last write leaves the flag set.
- R6: A bus read that returns 1 for bit i, followed by a write with bit i at 0, clears flag i at the edge that ends the write cycle. Other bits are affected only by their own armed state and write bit.
- R7: Bit i is armed only by a read while flag i is 1. Any write disarms every bit, so a second 0 write after a write does not clear. A read while the flag is 0 does not arm it, even if the flag is set later.
- R8: If `evt[i]` and a qualifying clear of bit i fall in the same cycle, flag i is 1 afterwards.
- R9: An event on an armed, already-set bit, or on another bit, between the arming read and the clearing write does not stop the armed bits from clearing.
- R10: `irq` is 1 exactly when some flag i is 1 and `irq_mask[i]` is 1. A mask change reaches `irq` combinationally.
- R11: `rd_data[15:8]` always reads 0, whatever value was written to those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rd_en | input | 1 | Decoded read strobe for this register |
| wr_en | input | 1 | Decoded write strobe for this register |
| wr_data | input | 16 | Write data |
| evt | input | 8 | One-cycle event pulses, one per flag |
| irq_mask | input | 8 | Per-flag interrupt enable |
| rd_data | output | 16 | Register read value |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check these properties on every cycle:
- Event pulses always set their flag.
- Flags never drop without a write.
- A 1 write or an unarmed bit never clears a flag.
- Every write leaves all bits disarmed.
- A bit is never armed while its flag is 0.
- Armed 0-written bits without a coincident event clear.
- A zero mask keeps `irq` low.

Only the bench's scenarios can show the full order of events, because that order spans several cycles. These include a read of a 0 flag that is later set, events that land between the read and the write, a second write after a write, and the exact bit order of the status word. The bench covers them with directed sequences and with a cycle-by-cycle reference model.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  localparam int DEF_FLAG_COUNT = 8;
  localparam int DEF_REG_WIDTH  = 16;

  // Bit positions of the flags in the status word; the timer logic relies on this order.
  typedef enum int {
    FLG_CAP_A  = 0,
    FLG_CAP_B  = 1,
    FLG_CAP_C  = 2,
    FLG_CAP_D  = 3,
    FLG_OVF    = 4,
    FLG_ITV_1  = 5,
    FLG_ITV_2A = 6,
    FLG_ITV_2B = 7
  } flag_pos_e;

  // A clear qualifies when the bit was armed and the write carries a 0 for it.
  function automatic logic clear_hit(input logic wr, input logic armed, input logic wbit);
    return wr & armed & ~wbit;
  endfunction

  // An event always wins over a clear in the same cycle.
  function automatic logic flag_next(input logic cur, input logic ev, input logic clr);
    return ev | (cur & ~clr);
  endfunction

  // Any write disarms; a read that sees the flag at 1 arms.
  function automatic logic arm_next(input logic cur_arm, input logic flag,
                                    input logic rd, input logic wr);
    if (wr)
      return 1'b0;
    else if (rd && flag)
      return 1'b1;
    else
      return cur_arm;
  endfunction

endpackage

// File: rtl/tsr_flag_cell.sv
module tsr_flag_cell
  import tsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic evt,
  output logic flag,
  output logic armed,
  output logic clr_hit_o
);

  logic clr_now;

  always_comb clr_now = clear_hit(wr_en, armed, wr_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_next(flag, evt, clr_now);
      armed <= arm_next(armed, flag, rd_en, wr_en);
    end
  end

  assign clr_hit_o = clr_now;

endmodule

// File: rtl/tsr_read_path.sv
module tsr_read_path #(
  parameter int FLAG_COUNT = 8,
  parameter int REG_WIDTH  = 16
) (
  input  logic [FLAG_COUNT-1:0] flags,
  output logic [REG_WIDTH-1:0]  rd_data
);

  localparam int PAD_W = REG_WIDTH - FLAG_COUNT;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, flags};
    end else begin : g_nopad
      assign rd_data = flags[REG_WIDTH-1:0];
    end
  endgenerate

endmodule

// File: rtl/tsr_irq_merge.sv
module tsr_irq_merge #(
  parameter int FLAG_COUNT = 8
) (
  input  logic [FLAG_COUNT-1:0] flags,
  input  logic [FLAG_COUNT-1:0] mask,
  output logic                  irq
);

  logic [FLAG_COUNT-1:0] gated;

  always_comb begin
    gated = flags & mask;
    irq   = |gated;
  end

endmodule

// File: rtl/tsr_status_reg.sv
module tsr_status_reg
  import tsr_pkg::*;
#(
  parameter int FLAG_COUNT = DEF_FLAG_COUNT,
  parameter int REG_WIDTH  = DEF_REG_WIDTH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [REG_WIDTH-1:0]  wr_data,
  input  logic [FLAG_COUNT-1:0] evt,
  input  logic [FLAG_COUNT-1:0] irq_mask,
  output logic [REG_WIDTH-1:0]  rd_data,
  output logic                  irq
);

  // Internal state brought out as named wires for the checker.
  logic [FLAG_COUNT-1:0] flags;
  logic [FLAG_COUNT-1:0] armed;
  logic [FLAG_COUNT-1:0] clr_hit;

  generate
    for (genvar i = 0; i < FLAG_COUNT; i++) begin : g_flag
      tsr_flag_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_bit    (wr_data[i]),
        .evt       (evt[i]),
        .flag      (flags[i]),
        .armed     (armed[i]),
        .clr_hit_o (clr_hit[i])
      );
    end
  endgenerate

  tsr_read_path #(
    .FLAG_COUNT (FLAG_COUNT),
    .REG_WIDTH  (REG_WIDTH)
  ) u_read (
    .flags   (flags),
    .rd_data (rd_data)
  );

  tsr_irq_merge #(
    .FLAG_COUNT (FLAG_COUNT)
  ) u_irq (
    .flags (flags),
    .mask  (irq_mask),
    .irq   (irq)
  );

endmodule

// File: rtl/tsr_status_reg_chk.sv
module tsr_status_reg_chk #(
  parameter int FLAG_COUNT = 8,
  parameter int REG_WIDTH  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [REG_WIDTH-1:0]  wr_data,
  input logic [FLAG_COUNT-1:0] evt,
  input logic [FLAG_COUNT-1:0] irq_mask,
  input logic                  irq,
  input logic [FLAG_COUNT-1:0] flags,
  input logic [FLAG_COUNT-1:0] armed
);

  logic [FLAG_COUNT-1:0] wlow;
  assign wlow = wr_data[FLAG_COUNT-1:0];

  // R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  // R5
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((flags & $past(flags)) == $past(flags)));

  // R4
  one_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flags & $past(flags & wlow)) == $past(flags & wlow)));

  // R7
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flags & $past(flags & ~armed)) == $past(flags & ~armed)));

  // R7
  write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (armed == '0));

  // R7
  arm_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed & ~flags) == '0);

  // R6
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flags & $past(armed & ~wlow & ~evt)) == '0));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

endmodule

bind tsr_status_reg tsr_status_reg_chk #(
  .FLAG_COUNT (FLAG_COUNT),
  .REG_WIDTH  (REG_WIDTH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .evt      (evt),
  .irq_mask (irq_mask),
  .irq      (irq),
  .flags    (flags),
  .armed    (armed)
);

// File: tb/tsr_status_reg_test.sv
`timescale 1ns/1ps
module tsr_status_reg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  evt = '0;
  logic [7:0]  irq_mask = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit model_on = 0;

  always #4 clk = ~clk; // 125 MHz

  tsr_status_reg uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .evt(evt), .irq_mask(irq_mask),
    .rd_data(rd_data), .irq(irq)
  );

  // Behavioural reference: a list of set flags and a list of "seen" bits.
  int ref_flag[8];
  int ref_seen[8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin ref_flag[k] = 0; ref_seen[k] = 0; end
    end else begin
      int nf[8];
      int ns[8];
      for (int k = 0; k < 8; k++) begin
        nf[k] = ref_flag[k];
        ns[k] = ref_seen[k];
        if (wr_en) begin
          if (ref_seen[k] == 1 && wr_data[k] == 1'b0) nf[k] = 0;
          ns[k] = 0;
        end else if (rd_en && ref_flag[k] == 1) begin
          ns[k] = 1;
        end
        if (evt[k]) nf[k] = 1;
      end
      for (int k = 0; k < 8; k++) begin ref_flag[k] = nf[k]; ref_seen[k] = ns[k]; end
    end
  end

  function automatic logic [15:0] ref_word();
    logic [15:0] w = '0;
    for (int k = 0; k < 8; k++) if (ref_flag[k] == 1) w[k] = 1'b1;
    return w;
  endfunction

  function automatic logic ref_irq();
    logic any = 1'b0;
    for (int k = 0; k < 8; k++) if (ref_flag[k] == 1 && irq_mask[k]) any = 1'b1;
    return any;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare against the model on every clock, after both have updated.
  always @(posedge clk) begin
    #2;
    if (model_on && rst_n) begin
      chk(rd_data === ref_word(), "R2 R11 model rd_data", rd_data, ref_word());
      chk(irq === ref_irq(), "R10 model irq", {15'b0, irq}, {15'b0, ref_irq()});
    end
  end

  task automatic step(input logic r, input logic w, input logic [15:0] d, input logic [7:0] e);
    @(negedge clk);
    rd_en = r; wr_en = w; wr_data = d; evt = e;
    @(posedge clk);
    #3;
    rd_en = 1'b0; wr_en = 1'b0; wr_data = '0; evt = '0;
  endtask

  task automatic expect_word(input logic [15:0] exp, input string tag);
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1 reset state
    expect_word(16'h0000, "R1 reset rd_data");
    chk(irq === 1'b0, "R1 reset irq", {15'b0, irq}, 16'h0);
    rst_n = 1'b1;
    model_on = 1;

    // R3 set and sticky
    step(0, 0, 16'h0, 8'h01);
    expect_word(16'h0001, "R3 capture A set");
    step(0, 0, 16'h0, 8'h00);
    expect_word(16'h0001, "R3 sticky");

    // R5 zero write without read
    step(0, 1, 16'h0000, 8'h00);
    expect_word(16'h0001, "R5 unarmed zero write");

    // R4 one write after arming read; R11 upper bits
    step(1, 0, 16'h0, 8'h00);
    step(0, 1, 16'hFFFF, 8'h00);
    expect_word(16'h0001, "R4 R11 one write");
    // R7 that write disarmed the bit
    step(0, 1, 16'h0000, 8'h00);
    expect_word(16'h0001, "R7 second write no clear");

    // R6 read then zero write
    step(1, 0, 16'h0, 8'h00);
    step(0, 1, 16'h0000, 8'h00);
    expect_word(16'h0000, "R6 clear");

    // R2 bit mapping
    step(0, 0, 16'h0, 8'hA5);
    expect_word(16'h00A5, "R2 map A5");

    // R9 event between read and write
    step(1, 0, 16'h0, 8'h00);
    step(0, 0, 16'h0, 8'h02);
    expect_word(16'h00A7, "R9 mid event");
    step(0, 1, 16'h0000, 8'h00);
    expect_word(16'h0002, "R9 armed bits cleared");

    // R8 event wins over clear
    step(1, 0, 16'h0, 8'h00);
    step(0, 1, 16'h0000, 8'h02);
    expect_word(16'h0002, "R8 event wins");
    step(1, 0, 16'h0, 8'h00);
    step(0, 1, 16'h0000, 8'h00);
    expect_word(16'h0000, "R6 clear after R8");

    // R6 per-bit selective clear, R7 disarm afterwards
    step(0, 0, 16'h0, 8'h30);
    step(1, 0, 16'h0, 8'h00);
    step(0, 1, 16'hFFDF, 8'h00);
    expect_word(16'h0010, "R6 selective clear");
    step(0, 1, 16'h0000, 8'h00);
    expect_word(16'h0010, "R7 disarmed after write");
    step(1, 0, 16'h0, 8'h00);
    step(0, 1, 16'h0000, 8'h00);
    expect_word(16'h0000, "R6 clear overflow");

    // R7 read of a 0 flag does not arm
    step(1, 0, 16'h0, 8'h00);
    step(0, 0, 16'h0, 8'h08);
    step(0, 1, 16'h0000, 8'h00);
    expect_word(16'h0008, "R7 read of zero not armed");
    step(1, 0, 16'h0, 8'h00);
    step(0, 1, 16'h0000, 8'h00);
    expect_word(16'h0000, "R6 clear capture D");

    // R10 interrupt masking
    step(0, 0, 16'h0, 8'h10);
    chk(irq === 1'b0, "R10 mask zero", {15'b0, irq}, 16'h0);
    @(negedge clk); irq_mask = 8'h10; #1;
    chk(irq === 1'b1, "R10 enabled bit", {15'b0, irq}, 16'h1);
    irq_mask = 8'hEF; #1;
    chk(irq === 1'b0, "R10 other bits", {15'b0, irq}, 16'h0);

    // R11 write to reserved bits
    step(0, 1, 16'hFF00, 8'h00);
    chk(rd_data[15:8] === 8'h00, "R11 reserved zero", {8'h0, rd_data[15:8]}, 16'h0);

    // Random traffic against the model (R3 R4 R5 R6 R7 R8 R9 R10)
    for (int n = 0; n < 400; n++) begin
      logic [7:0] ev;
      ev = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      @(negedge clk);
      irq_mask = 8'($urandom);
      step($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, 16'($urandom), ev);
    end

    repeat (2) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule